// File: doc/BRIEF.md
# Four-Channel Audio Period Divider with Pair Joining

This block produces the period-expiry pulses that drive four audio tone channels. Each channel owns an 8-bit period value and counts ticks of its selected clock. When the count runs out the channel emits a one-cycle pulse and starts counting again from the same period. The block runs on the fast system clock, which is about 1.79 MHz in the target use. From that clock it derives a slow base tick of about 64 kHz or about 15.7 kHz. Channels 1 and 3 can run on the fast clock itself instead of the base tick.

A mode byte controls the block. It picks the base rate, the per-channel fast clock and the pairing of channels. Channels 1 and 2, and channels 3 and 4, can be paired into one 16-bit divider. The low channel supplies the low byte and the clock choice. The high channel supplies the high byte and carries the pulse. A write of any non-zero value to the reload port restarts every counter from its period. The top bit of the mode byte is passed on, one cycle later, to the polynomial noise source.

Top module: `audio_clk_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `expire_o` and `poly9_o` are 0. All counters leave reset at 0, so each channel fires on its first clock tick.
- R2: The base tick occurs once every 28 system clocks when `mode_i[0]`=0 and once every 114 when `mode_i[0]`=1. An unpaired channel on the base tick with period P pulses once every (P+1) base ticks.
- R3: `mode_i[6]`=1 moves channel 1 (period byte 0, output bit 0) to the system clock, and `mode_i[5]`=1 does the same for channel 3 (byte 2, bit 2). An unpaired channel on the system clock pulses once every P+4 cycles.
- R4: `mode_i[4]`=1 joins channels 1 and 2 into one divider with period {byte 1, byte 0}. The pair pulses every P+1 base ticks, or every P+7 system clocks when `mode_i[6]`=1. The pulse appears on bit 1, and bit 0 stays 0 from the cycle after the join is set.
- R5: `mode_i[3]`=1 joins channels 3 and 4 in the same way, with period {byte 3, byte 2}, clock choice from `mode_i[5]`, and the pulse on bit 3 while bit 2 stays 0.
- R6: A cycle with `reload_we_i`=1 and a non-zero `reload_data_i` loads every counter with its current period count and suppresses pulses in that cycle. A write of 0 has no effect.
- R7: `poly9_o` follows `mode_i[7]` with a delay of one cycle.
- R8: Channels 2 and 4, when not joined, always run on the base tick, whatever the fast-clock bits are.
- R9: Each expiry pulse is registered and appears in the cycle after the tick on which the counter reached 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (fast audio clock) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 8 | Mode byte: base rate, fast-clock selects, pair joins, short-polynomial flag |
| period_i | input | 4x8 | Period bytes, index n belongs to channel n+1 |
| reload_we_i | input | 1 | Reload register write strobe |
| reload_data_i | input | 8 | Reload write data; only a non-zero value acts |
| expire_o | output | 4 | One-cycle expiry pulse per channel |
| poly9_o | output | 1 | Short-polynomial select for the noise source |

## Verification
The assertions assume that every base divisor is at least 2, so that two base ticks never come in adjacent cycles. They also assume that the mode and period inputs are level-driven, with no timing tie to the reload strobe. The stimulus holds the divisors at their default values. It changes mode, periods and reload strobes only between clock edges and covers every join and fast-clock combination. It mixes in both zero and non-zero reload writes.

// File: rtl/acp_pkg.sv
package acp_pkg;
  localparam int unsigned PER_W      = 8;
  localparam int unsigned N_PAIR     = 2;
  localparam int unsigned FAST_ADD8  = 3;  // P+4 ticks -> load P+3
  localparam int unsigned FAST_ADD16 = 6;  // P+7 ticks -> load P+6
endpackage

// File: rtl/acp_base_tick.sv
module acp_base_tick #(
  parameter int unsigned DIV_FAST = 28,
  parameter int unsigned DIV_SLOW = 114,
  localparam int unsigned DW = $clog2(DIV_SLOW + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_i,
  output logic tick_o
);
  logic [DW-1:0] div_q;
  logic [DW-1:0] lim;

  assign lim    = slow_i ? DW'(DIV_SLOW - 1) : DW'(DIV_FAST - 1);
  assign tick_o = (div_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

  p_tick_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/acp_div_cnt.sv
module acp_div_cnt #(
  parameter int unsigned W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         reload_i,
  input  logic [W-1:0] load_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;

  assign hit_o = tick_i && !reload_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (reload_i || hit_o) cnt_q <= load_i;
    else if (tick_i)            cnt_q <= cnt_q - 1'b1;
  end

  p_reload_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> cnt_q == $past(load_i));
  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !reload_i) |=> $stable(cnt_q));
endmodule

// File: rtl/acp_chan_pair.sv
module acp_chan_pair
  import acp_pkg::*;
#(
  parameter int unsigned PW = PER_W,
  localparam int unsigned LW = 2*PW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          base_tick_i,
  input  logic          fast_i,
  input  logic          join_i,
  input  logic          reload_i,
  input  logic [PW-1:0] per_lo_i,
  input  logic [PW-1:0] per_hi_i,
  output logic          lo_o,
  output logic          hi_o
);
  logic          lo_tick, lo_hit, hi_hit;
  logic [LW-1:0] lo_load;
  logic          lo_q, hi_q;

  assign lo_tick = fast_i | base_tick_i;
  always_comb begin
    if (join_i) lo_load = LW'({per_hi_i, per_lo_i}) + (fast_i ? LW'(FAST_ADD16) : '0);
    else        lo_load = LW'(per_lo_i) + (fast_i ? LW'(FAST_ADD8) : '0);
  end

  acp_div_cnt #(.W(LW)) u_lo (
    .clk_i, .rst_ni, .tick_i(lo_tick), .reload_i, .load_i(lo_load), .hit_o(lo_hit)
  );
  acp_div_cnt #(.W(PW)) u_hi (
    .clk_i, .rst_ni, .tick_i(base_tick_i), .reload_i, .load_i(per_hi_i), .hit_o(hi_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= 1'b0;
      hi_q <= 1'b0;
    end else begin
      lo_q <= lo_hit & ~join_i;
      hi_q <= join_i ? lo_hit : hi_hit;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;

  p_lo_mute_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    join_i |=> !lo_o);
  p_hi_slow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!join_i && !base_tick_i) |=> !hi_o);
  p_no_pulse_on_reload_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> !lo_o && !hi_o);
endmodule

// File: rtl/audio_clk_ctrl.sv
module audio_clk_ctrl
  import acp_pkg::*;
#(
  parameter int unsigned DIV_FAST = 28,
  parameter int unsigned DIV_SLOW = 114,
  localparam int unsigned NCH = 2*N_PAIR
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [7:0]                mode_i,
  input  logic [NCH-1:0][PER_W-1:0] period_i,
  input  logic                      reload_we_i,
  input  logic [7:0]                reload_data_i,
  output logic [NCH-1:0]            expire_o,
  output logic                      poly9_o
);
  logic base_tick;
  logic reload;
  logic poly9_q;

  assign reload = reload_we_i && (reload_data_i != 8'd0);

  acp_base_tick #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_base (
    .clk_i, .rst_ni, .slow_i(mode_i[0]), .tick_o(base_tick)
  );

  for (genvar g = 0; g < N_PAIR; g++) begin : g_pair
    acp_chan_pair #(.PW(PER_W)) u_pair (
      .clk_i,
      .rst_ni,
      .base_tick_i(base_tick),
      .fast_i     (mode_i[6-g]),
      .join_i     (mode_i[4-g]),
      .reload_i   (reload),
      .per_lo_i   (period_i[2*g]),
      .per_hi_i   (period_i[2*g+1]),
      .lo_o       (expire_o[2*g]),
      .hi_o       (expire_o[2*g+1])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) poly9_q <= 1'b0;
    else         poly9_q <= mode_i[7];
  end
  assign poly9_o = poly9_q;

  p_poly_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> poly9_o == $past(mode_i[7]));
  p_join34_mute_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[3] |=> !expire_o[2]);
endmodule

// File: tb/audio_clk_ctrl_test.sv
module audio_clk_ctrl_test;
  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [7:0]      mode = 8'h00;
  logic [3:0][7:0] per = '0;
  logic            we = 1'b0;
  logic [7:0]      wdata = 8'h00;
  logic [3:0]      expire;
  logic            poly9;

  audio_clk_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .period_i(per),
    .reload_we_i(we), .reload_data_i(wdata), .expire_o(expire), .poly9_o(poly9)
  );

  always #2.5 clk = ~clk;

  int vectors = 0, fails = 0;
  int pulses = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural reference
  int div, lo_c[2], hi_c[2];
  bit [3:0] m_exp;
  bit m_p9;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div = 0; lo_c = '{0, 0}; hi_c = '{0, 0}; m_exp = '0; m_p9 = 0;
    end else begin
      int d, lload;
      bit bt, fast, jn, rl, lt, lh, hh;
      d  = mode[0] ? 114 : 28;
      bt = (div >= d - 1);
      div = bt ? 0 : div + 1;
      rl = we && (wdata != 0);
      for (int g = 0; g < 2; g++) begin
        fast = mode[6-g]; jn = mode[4-g];
        lt = fast || bt;
        lload = jn ? (int'(per[2*g+1]) * 256 + int'(per[2*g]) + (fast ? 6 : 0))
                   : (int'(per[2*g]) + (fast ? 3 : 0));
        lh = 0; hh = 0;
        if (rl) lo_c[g] = lload;
        else if (lt) begin
          if (lo_c[g] == 0) begin lh = 1; lo_c[g] = lload; end
          else lo_c[g]--;
        end
        if (rl) hi_c[g] = int'(per[2*g+1]);
        else if (bt) begin
          if (hi_c[g] == 0) begin hh = 1; hi_c[g] = int'(per[2*g+1]); end
          else hi_c[g]--;
        end
        m_exp[2*g]   = lh && !jn;
        m_exp[2*g+1] = jn ? lh : hh;
      end
      m_p9 = mode[7];
    end
  end

  always @(negedge clk) if (!done) begin
    vectors++;
    if (expire != 0) pulses++;
    if (expire !== m_exp) begin
      fails++;
      $display("FAIL %s expire act %b exp %b", tag, expire, m_exp);
    end
    if (poly9 !== m_p9) begin
      fails++;
      $display("FAIL %s poly9 act %b exp %b", tag, poly9, m_p9);
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] v);
    @(negedge clk); we = 1'b1; wdata = v;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic finish_up();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act timeout exp finish");
    finish_up();
  end

  initial begin
    tag = "R1"; run(5);
    @(negedge clk); rst_n = 1'b1;
    run(2);
    tag = "R2_base28"; mode = 8'h00; per = {8'd5, 8'd0, 8'd3, 8'd2};
    run(2000);
    tag = "R2_base114"; mode = 8'h01;
    run(3000);
    tag = "R3_fast"; mode = 8'h60; per = {8'd1, 8'd0, 8'd2, 8'd10};
    run(600);
    tag = "R8_hi_slow"; mode = 8'h61;
    run(1200);
    tag = "R4_join12_fast"; mode = 8'h50; per = {8'd0, 8'd1, 8'd1, 8'd2};
    run(1500);
    tag = "R5_join34_base"; mode = 8'h08; per = {8'd0, 8'd1, 8'd0, 8'd4};
    run(1500);
    tag = "R5_join34_fast"; mode = 8'h38; per = {8'd1, 8'd3, 8'd0, 8'd1};
    run(1500);
    tag = "R6_reload"; mode = 8'h78; per = {8'd0, 8'd40, 8'd0, 8'd90};
    for (int i = 0; i < 10; i++) begin
      run(37 + i);
      wr((i % 2) ? 8'h00 : 8'h81);
    end
    mode = 8'h60; per = {8'd3, 8'd20, 8'd4, 8'd30};
    for (int i = 0; i < 8; i++) begin
      run(15);
      wr(i[0] ? 8'h01 : 8'h00);
    end
    tag = "R7_poly"; 
    for (int i = 0; i < 6; i++) begin
      mode = {i[0], 7'h10};
      run(3);
    end
    tag = "R9_mix"; mode = 8'h29; per = {8'd2, 8'd0, 8'd1, 8'd0};
    run(1000);
    if (pulses == 0) begin
      fails++;
      $display("FAIL R2 pulses act 0 exp nonzero");
    end
    finish_up();
  end
endmodule